// File: doc/BRIEF.md
# Round-Key Cache with Key-Change Detection

This block sits in front of a block-cipher key-expansion engine. It keeps the last master key (128 bits) that was fully expanded, together with the 32 round keys of 32 bits each that were derived from it. Each time a new master key is loaded, the block compares it with the stored key. When the keys are equal and the cached set is complete, the block reports a hit and the cipher datapath reads round keys straight from storage. No expansion takes place, so no extra cycles or switching activity are spent on it.

When the keys differ, or the cache holds no complete set, the block pulses a start request to the expansion engine. It then accepts the round keys that the engine streams back and writes them in arrival order. After the last of them arrives, the cache is marked valid. The cached set can serve any number of consecutive data blocks. A read port returns the round keys in forward order for encryption. For decryption it returns them in reverse order, with round key 31 first and round key 0 last.

The round-key stream from the engine is a valid/ready interface. The ready signal is high for the whole of a fill, so the cache never applies back-pressure once a fill has started. Outside a fill, ready is low and any offered word is dropped. The engine may leave gaps between words.

Top module: `round_key_cache`

## Requirements
- R1: After reset, key_hit, key_ready, exp_start, exp_rk_ready and rd_valid are low, rd_key is zero and the cache is invalid, so the first key_load misses whatever the key value is (including all zeros).
- R2: A key_load whose key equals the stored key while the cache is valid sets key_hit and key_ready high in the next cycle, keeps exp_start low and starts no fill.
- R3: A key_load that misses (unequal key or invalid cache) gives a one-cycle exp_start pulse in the next cycle, drives key_hit and key_ready low, and raises exp_rk_ready.
- R4: During a fill, exp_rk_ready stays high and each cycle with exp_rk_valid and exp_rk_ready high stores exp_rk at the next index, starting at 0. Idle cycles between words are allowed.
- R5: In the cycle after the 32nd word is accepted, exp_rk_ready is low, key_ready is high and the cache is valid for the loaded key.
- R6: exp_abort during a fill ends the fill and leaves the cache invalid with key_ready low, so the next key_load misses even for the same key. exp_abort outside a fill changes nothing.
- R7: A key_load during a fill restarts the fill as a miss, with the write index back at 0.
- R8: exp_rk_valid while exp_rk_ready is low is ignored, and the stored round keys stay unchanged.
- R9: A cycle with rd_req high returns, in the next cycle, rd_valid high and rd_key equal to rk[rd_idx] when rd_decrypt is 0, or rk[31-rd_idx] when rd_decrypt is 1. Without rd_req, rd_valid is low and rd_key holds its value.
- R10: key_hit and key_ready keep their values across any number of reads, up to the next key_load or the next event that ends a fill.
- R11: When key_load arrives in the same cycle as exp_abort or exp_rk_valid, key_load takes priority, and no word is written in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_load | input | 1 | Presents key_in for comparison |
| key_in | input | 128 | New master key |
| key_hit | output | 1 | Last load matched the cached key |
| key_ready | output | 1 | Round keys for the current key are available |
| exp_start | output | 1 | One-cycle request to the expansion engine |
| exp_rk_valid | input | 1 | Round-key word from the engine is valid |
| exp_rk_ready | output | 1 | Cache accepts round-key words (fill in progress) |
| exp_rk | input | 32 | Round-key word from the engine |
| exp_abort | input | 1 | Engine abandons the current expansion |
| rd_req | input | 1 | Round-key read request |
| rd_decrypt | input | 1 | 0: forward index, 1: reverse index |
| rd_idx | input | 5 | Round index requested |
| rd_valid | output | 1 | rd_key holds the answer to the previous request |
| rd_key | output | 32 | Round key read out |

## Verification
The first load uses an all-zero key against a freshly reset, zero-filled cache, which separates a true miss from a match on stale contents. The bench then reloads the same key, which tells a real hit apart from a design that always expands, and loads a different key, which exposes a comparator that ignores some of the bits. Fills are driven both back-to-back and with idle gaps. Fills are also cut short by an abort, and restarted by a load in mid-fill, which shows whether the write index and the valid flag are handled correctly. Every index is read in both orders after each fill, so swapped or mirrored storage shows up directly.

// File: rtl/rkc_pkg.sv
package rkc_pkg;
  typedef enum logic {
    ORDER_FWD = 1'b0,
    ORDER_REV = 1'b1
  } rk_order_e;
endpackage

// File: rtl/rkc_compare.sv
module rkc_compare #(
  parameter int KEY_W = 128,
  parameter int SLICE_W = 32
) (
  input  logic [KEY_W-1:0] key_in,
  input  logic [KEY_W-1:0] stored_key,
  input  logic             cache_valid,
  output logic             match
);
  localparam int N_SLICE = KEY_W / SLICE_W;

  logic [N_SLICE-1:0] slice_eq;

  genvar g;
  generate
    for (g = 0; g < N_SLICE; g++) begin : g_slice
      assign slice_eq[g] = (key_in[g*SLICE_W +: SLICE_W] == stored_key[g*SLICE_W +: SLICE_W]);
    end
  endgenerate

  assign match = cache_valid && (&slice_eq);
endmodule

// File: rtl/rkc_ctrl.sv
module rkc_ctrl #(
  parameter int KEY_W = 128,
  parameter int NUM_RK = 32,
  localparam int IDX_W = $clog2(NUM_RK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_load,
  input  logic [KEY_W-1:0] key_in,
  input  logic             match,
  input  logic             exp_rk_valid,
  input  logic             exp_abort,
  output logic [KEY_W-1:0] stored_key,
  output logic             cache_valid,
  output logic             key_hit,
  output logic             key_ready,
  output logic             exp_start,
  output logic             filling,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_RK - 1);

  logic last_word;

  assign wr_en     = filling && exp_rk_valid && !key_load && !exp_abort;
  assign last_word = (wr_idx == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stored_key  <= '0;
      cache_valid <= 1'b0;
      key_hit     <= 1'b0;
      key_ready   <= 1'b0;
      exp_start   <= 1'b0;
      filling     <= 1'b0;
      wr_idx      <= '0;
    end else if (key_load) begin
      key_hit   <= match;
      key_ready <= match;
      exp_start <= !match;
      if (!match) begin
        stored_key  <= key_in;
        cache_valid <= 1'b0;
        filling     <= 1'b1;
        wr_idx      <= '0;
      end
    end else begin
      exp_start <= 1'b0;
      if (filling && exp_abort) begin
        filling     <= 1'b0;
        cache_valid <= 1'b0;
        key_ready   <= 1'b0;
      end else if (wr_en) begin
        wr_idx <= wr_idx + 1'b1;
        if (last_word) begin
          filling     <= 1'b0;
          cache_valid <= 1'b1;
          key_ready   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rkc_store.sv
module rkc_store #(
  parameter int RK_W = 32,
  parameter int NUM_RK = 32,
  localparam int IDX_W = $clog2(NUM_RK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [RK_W-1:0]  wr_data,
  input  logic             rd_req,
  input  logic             rd_decrypt,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [RK_W-1:0]  rd_key
);
  import rkc_pkg::*;

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_RK - 1);

  logic [RK_W-1:0]  slot [NUM_RK];
  logic [IDX_W-1:0] phys_idx;
  rk_order_e        order;

  assign order    = rk_order_e'(rd_decrypt);
  assign phys_idx = (order == ORDER_REV) ? (TOP_IDX - rd_idx) : rd_idx;

  genvar g;
  generate
    for (g = 0; g < NUM_RK; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          slot[g] <= '0;
        else if (wr_en && (wr_idx == IDX_W'(g)))
          slot[g] <= wr_data;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_key   <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req)
        rd_key <= slot[phys_idx];
    end
  end
endmodule

// File: rtl/round_key_cache.sv
module round_key_cache #(
  parameter int KEY_W = 128,
  parameter int RK_W = 32,
  parameter int NUM_RK = 32,
  localparam int IDX_W = $clog2(NUM_RK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_load,
  input  logic [KEY_W-1:0] key_in,
  output logic             key_hit,
  output logic             key_ready,
  output logic             exp_start,
  input  logic             exp_rk_valid,
  output logic             exp_rk_ready,
  input  logic [RK_W-1:0]  exp_rk,
  input  logic             exp_abort,
  input  logic             rd_req,
  input  logic             rd_decrypt,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [RK_W-1:0]  rd_key
);
  logic [KEY_W-1:0] stored_key;
  logic             cache_valid;
  logic             match;
  logic             filling;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;

  rkc_compare #(.KEY_W(KEY_W), .SLICE_W(RK_W)) u_cmp (
    .key_in      (key_in),
    .stored_key  (stored_key),
    .cache_valid (cache_valid),
    .match       (match)
  );

  rkc_ctrl #(.KEY_W(KEY_W), .NUM_RK(NUM_RK)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .key_load     (key_load),
    .key_in       (key_in),
    .match        (match),
    .exp_rk_valid (exp_rk_valid),
    .exp_abort    (exp_abort),
    .stored_key   (stored_key),
    .cache_valid  (cache_valid),
    .key_hit      (key_hit),
    .key_ready    (key_ready),
    .exp_start    (exp_start),
    .filling      (filling),
    .wr_en        (wr_en),
    .wr_idx       (wr_idx)
  );

  rkc_store #(.RK_W(RK_W), .NUM_RK(NUM_RK)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (exp_rk),
    .rd_req     (rd_req),
    .rd_decrypt (rd_decrypt),
    .rd_idx     (rd_idx),
    .rd_valid   (rd_valid),
    .rd_key     (rd_key)
  );

  assign exp_rk_ready = filling;
endmodule

// File: rtl/rkc_checker.sv
module rkc_checker (
  input logic clk,
  input logic rst_n,
  input logic key_load,
  input logic key_hit,
  input logic key_ready,
  input logic exp_start,
  input logic exp_rk_ready,
  input logic exp_abort,
  input logic rd_req,
  input logic rd_valid
);
  // R2 / R3: a load is answered by hit and ready agreeing
  a_r2_hit_ready_agree: assert property (@(posedge clk) disable iff (!rst_n)
    key_load |=> (key_hit == key_ready));

  // R2 / R3: a load either hits or requests an expansion, never both
  a_r3_start_xor_hit: assert property (@(posedge clk) disable iff (!rst_n)
    key_load |=> (key_hit != exp_start));

  // R3: the start request lasts exactly one cycle
  a_r3_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_start && !key_load) |=> !exp_start);

  // R4 / R5: keys are never reported ready while a fill is in progress
  a_r5_no_ready_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
    exp_rk_ready |-> !key_ready);

  // R6: an abort without a load ends any fill
  a_r6_abort_ends_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_abort && !key_load) |=> !exp_rk_ready);

  // R10: a hit implies usable round keys
  a_r10_hit_implies_ready: assert property (@(posedge clk) disable iff (!rst_n)
    key_hit |-> key_ready);

  // R9: read response follows the request by one cycle
  a_r9_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);
  a_r9_no_spurious_read: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);
endmodule

bind round_key_cache rkc_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .key_load     (key_load),
  .key_hit      (key_hit),
  .key_ready    (key_ready),
  .exp_start    (exp_start),
  .exp_rk_ready (exp_rk_ready),
  .exp_abort    (exp_abort),
  .rd_req       (rd_req),
  .rd_valid     (rd_valid)
);

// File: tb/round_key_cache_test.sv
module round_key_cache_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         key_load = 1'b0;
  logic [127:0] key_in = '0;
  logic         key_hit, key_ready, exp_start, exp_rk_ready, rd_valid;
  logic         exp_rk_valid = 1'b0;
  logic [31:0]  exp_rk = '0;
  logic         exp_abort = 1'b0;
  logic         rd_req = 1'b0;
  logic         rd_decrypt = 1'b0;
  logic [4:0]   rd_idx = '0;
  logic [31:0]  rd_key;

  int checks = 0;
  int errors = 0;
  string phase = "R1";
  bit done = 1'b0;

  always #2 clk = ~clk;

  round_key_cache uut (
    .clk(clk), .rst_n(rst_n), .key_load(key_load), .key_in(key_in),
    .key_hit(key_hit), .key_ready(key_ready), .exp_start(exp_start),
    .exp_rk_valid(exp_rk_valid), .exp_rk_ready(exp_rk_ready), .exp_rk(exp_rk),
    .exp_abort(exp_abort), .rd_req(rd_req), .rd_decrypt(rd_decrypt),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_key(rd_key)
  );

  // behavioural reference model
  logic [31:0]  m_rk [32];
  logic [127:0] m_key = '0;
  bit           m_valid = 0, m_fill = 0, m_hit = 0, m_ready = 0, m_start = 0, m_rdv = 0;
  int           m_idx = 0;
  logic [31:0]  m_rdk = '0;

  initial for (int i = 0; i < 32; i++) m_rk[i] = '0;

  always @(posedge clk) begin
    if (rst_n) begin
      bit h;
      m_rdv = rd_req;
      if (rd_req) m_rdk = m_rk[rd_decrypt ? 31 - int'(rd_idx) : int'(rd_idx)];
      if (key_load) begin
        h = m_valid && (key_in == m_key);
        m_hit = h; m_ready = h; m_start = !h;
        if (!h) begin m_key = key_in; m_valid = 0; m_fill = 1; m_idx = 0; end
      end else begin
        m_start = 0;
        if (m_fill && exp_abort) begin
          m_fill = 0; m_valid = 0; m_ready = 0;
        end else if (m_fill && exp_rk_valid) begin
          m_rk[m_idx] = exp_rk;
          if (m_idx == 31) begin m_fill = 0; m_valid = 1; m_ready = 1; end
          m_idx++;
        end
      end
    end
  end

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(phase, "key_hit R2", 32'(key_hit), 32'(m_hit));
      check(phase, "key_ready R5", 32'(key_ready), 32'(m_ready));
      check(phase, "exp_start R3", 32'(exp_start), 32'(m_start));
      check(phase, "exp_rk_ready R4", 32'(exp_rk_ready), 32'(m_fill));
      check(phase, "rd_valid R9", 32'(rd_valid), 32'(m_rdv));
      check(phase, "rd_key R9", rd_key, m_rdk);
    end
  end

  function automatic logic [31:0] rk_of(logic [127:0] k, int i);
    logic [31:0] w;
    w = k[127:96] ^ k[31:0] ^ (32'(i) * 32'h9E37_79B9);
    return {w[26:0], w[31:27]} ^ k[63:32] ^ 32'(i + 1);
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic load(logic [127:0] k);
    key_load = 1; key_in = k; step(); key_load = 0;
  endtask

  task automatic feed(logic [127:0] k, int first, int last, int gap);
    for (int i = first; i <= last; i++) begin
      exp_rk_valid = 1; exp_rk = rk_of(k, i); step();
      exp_rk_valid = 0;
      for (int g = 0; g < gap; g++) step();
    end
  endtask

  task automatic read_all();
    for (int d = 0; d < 2; d++)
      for (int i = 0; i < 32; i++) begin
        rd_req = 1; rd_decrypt = d[0]; rd_idx = 5'(i); step();
      end
    rd_req = 0; step();
  endtask

  initial begin
    logic [127:0] ka, kb, kc;
    ka = '0;
    kb = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    kc = kb ^ 128'h1;
    #5;
    check("R1", "key_ready at reset", 32'(key_ready), 0);
    check("R1", "key_hit at reset", 32'(key_hit), 0);
    check("R1", "exp_rk_ready at reset", 32'(exp_rk_ready), 0);
    check("R1", "rd_valid at reset", 32'(rd_valid), 0);
    rst_n = 1; step();
    phase = "R1"; load(ka);                       // zero key still misses
    phase = "R4"; feed(ka, 0, 31, 0);
    phase = "R9"; read_all();
    phase = "R2"; load(ka); read_all();
    phase = "R10"; read_all();
    phase = "R6"; exp_abort = 1; step(); exp_abort = 0;  // outside a fill
    load(ka);
    phase = "R3"; load(kb);
    phase = "R4"; feed(kb, 0, 9, 2);
    phase = "R6"; exp_abort = 1; step(); exp_abort = 0; read_all();
    load(kb);
    phase = "R7"; feed(kb, 0, 5, 1); load(kc); feed(kc, 0, 31, 1);
    phase = "R9"; read_all();
    phase = "R8"; feed(kb, 0, 3, 0); read_all();
    phase = "R11";
    load(kb); exp_rk_valid = 1; exp_rk = 32'hDEAD_BEEF; key_load = 1; key_in = kb; step();
    key_load = 0; exp_abort = 1; exp_rk_valid = 0; step(); exp_abort = 0;
    key_load = 1; key_in = kb; exp_abort = 1; step(); key_load = 0; exp_abort = 0;
    feed(kb, 0, 31, 0); read_all();
    phase = "R2"; load(kb); load(kc); feed(kc, 0, 31, 0); load(kc); read_all();
    step(); step();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule